// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads one directory entry and then one table entry from memory over a word-wide port that carries one access at a time. The directory is found through a frame-number register. A single enable input chooses between a full walk and a direct pass-through. At each level the walker checks that the entry is present. It then applies the user/supervisor and read/write permissions to the access.

Before a walk completes, the walker writes back any entry whose accessed or dirty flag has to change. On success it returns the physical address together with the two cache-policy flags of the final entry. On failure it raises a fault with a three-bit cause and latches the faulting linear address. One request is accepted at a time. The result stays on the outputs until the next request is accepted.

Top module: `pt_walker`

## Requirements
- R1: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a byte offset (bits 11:0). Each entry is read from the word address {frame number, index, 2'b00}. The directory frame comes from `dir_base` and the table frame from bits 31:12 of the directory entry.
- R2: With `xlat_en` low, an accepted request completes on the next clock with `paddr` equal to the linear address, `pwt`/`pcd` low, no fault and no memory access.
- R3: If bit 0 (present) of an entry is clear at either level, the walk stops with a not-present fault. The other bits of that entry have no effect, and no entry is written.
- R4: A user-mode access faults with a protection violation unless bit 2 is set in both entries. A supervisor-mode access ignores bit 2.
- R5: A write faults with a protection violation unless bit 1 is set in both entries. This holds for supervisor and user mode alike.
- R6: On a permitted level, bit 5 (accessed) is set in the entry. In the table entry, bit 6 (dirty) is also set on a write. An entry is written back only when its value changes. The directory write-back happens before the table read. A faulting entry is never written.
- R7: `fault_code` bit 0 is 1 for a protection violation and 0 for not-present. Bit 1 is the write flag and bit 2 the user flag of the access. `fault_addr` holds the faulting linear address.
- R8: On success, `paddr` = {table entry bits 31:12, offset}, `pwt` = table entry bit 3 and `pcd` = table entry bit 4.
- R9: `req_ready` is high only while idle. `done`/`fault` and the result stay stable until the next accepted request. While `mem_req` waits for `mem_ack`, the address, write flag and write data stay stable.
- R10: After reset, `req_ready` is high, and `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; low passes addresses through |
| dir_base | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Entry value read, valid with mem_ack |
| done | output | 1 | Translation finished successfully |
| fault | output | 1 | Translation ended in a page fault |
| paddr | output | 32 | Physical address |
| pwt | output | 1 | Write-through flag of the page |
| pcd | output | 1 | Cache-disable flag of the page |
| fault_code | output | 3 | {user, write, protection} fault cause |
| fault_addr | output | 32 | Latched faulting linear address |

## Verification
The walker is driven with user and supervisor reads and writes. Entries are chosen so that the accessed and dirty flags are already set, partly set or clear, which separates walks that need zero, one or two write-backs. Missing entries are tested at the directory level and at the table level, and the missing directory entry carries garbage in its other bits. Permission failures are tested from the user flag and from the read/write flag at each level, which tells apart the three cause bits and the place where the walk stops. The all-ones address and a pass-through request cover the index extremes and the bypass path. The memory latency is varied between walks to show that every transaction is matched against the reference sequence and not against a fixed timing.

// File: rtl/pw_pkg.sv
package pw_pkg;
    // Entry flag positions
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_PWT = 3;
    localparam int BIT_PCD = 4;
    localparam int BIT_A   = 5;
    localparam int BIT_D   = 6;

    // Fault cause positions
    localparam int FC_PROT  = 0;
    localparam int FC_WRITE = 1;
    localparam int FC_USER  = 2;
    localparam int FC_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WB_DIR,
        ST_RD_TBL,
        ST_WB_TBL
    } walk_st_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int FRAME_W = 20,
    parameter int IDX_W   = 10,
    localparam int ADDR_W = FRAME_W + IDX_W + 2
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   index,
    output logic [ADDR_W-1:0]  addr
);
    // Word-aligned entry address inside a frame
    assign addr = {frame, index, 2'b00};
endmodule

// File: rtl/pw_entry_eval.sv
module pw_entry_eval
    import pw_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             last_level,
    input  logic             is_write,
    input  logic             is_user,
    output logic             not_present,
    output logic             prot_viol,
    output logic [ENT_W-1:0] updated,
    output logic             changed
);
    logic [ENT_W-1:0] set_mask;

    always_comb begin
        not_present = ~entry[BIT_P];
        prot_viol   = entry[BIT_P] &
                      ((is_user & ~entry[BIT_US]) | (is_write & ~entry[BIT_RW]));
        set_mask         = '0;
        set_mask[BIT_A]  = 1'b1;
        set_mask[BIT_D]  = last_level & is_write;
        updated          = entry | set_mask;
        changed          = (updated != entry);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int DIR_W   = ADDR_W - OFF_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xlat_en,
    input  logic [FRAME_W-1:0] dir_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [ADDR_W-1:0]  paddr,
    output logic               pwt,
    output logic               pcd,
    output logic [FC_W-1:0]    fault_code,
    output logic [ADDR_W-1:0]  fault_addr
);
    typedef struct packed {
        walk_st_e           st;
        logic [ADDR_W-1:0]  vaddr;
        logic               write;
        logic               user;
        logic [FRAME_W-1:0] tbl_base;
        logic [ADDR_W-1:0]  wb_data;
        logic               done;
        logic               fault;
        logic [FC_W-1:0]    code;
        logic [ADDR_W-1:0]  fault_addr;
        logic [ADDR_W-1:0]  paddr;
        logic               pwt;
        logic               pcd;
    } walk_s;

    walk_s q, d;

    logic [ADDR_W-1:0] dir_addr, tbl_addr, ev_upd;
    logic              ev_np, ev_prot, ev_chg;

    pw_addr_gen #(.FRAME_W(FRAME_W), .IDX_W(DIR_W)) u_dir_addr (
        .frame (dir_base),
        .index (q.vaddr[ADDR_W-1 -: DIR_W]),
        .addr  (dir_addr)
    );

    pw_addr_gen #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_tbl_addr (
        .frame (q.tbl_base),
        .index (q.vaddr[OFF_W +: IDX_W]),
        .addr  (tbl_addr)
    );

    pw_entry_eval #(.ENT_W(ADDR_W)) u_eval (
        .entry       (mem_rdata),
        .last_level  (q.st == ST_RD_TBL),
        .is_write    (q.write),
        .is_user     (q.user),
        .not_present (ev_np),
        .prot_viol   (ev_prot),
        .updated     (ev_upd),
        .changed     (ev_chg)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = q.wb_data;
        req_ready = (q.st == ST_IDLE);

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.done  = 1'b0;
                    d.fault = 1'b0;
                    if (!xlat_en) begin
                        d.done  = 1'b1;
                        d.paddr = req_vaddr;
                        d.pwt   = 1'b0;
                        d.pcd   = 1'b0;
                    end else begin
                        d.st    = ST_RD_DIR;
                        d.vaddr = req_vaddr;
                        d.write = req_write;
                        d.user  = req_user;
                    end
                end
            end
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) begin
                    if (ev_np || ev_prot) begin
                        d.fault      = 1'b1;
                        d.code       = {q.user, q.write, ev_prot};
                        d.fault_addr = q.vaddr;
                        d.st         = ST_IDLE;
                    end else begin
                        d.tbl_base = mem_rdata[ADDR_W-1:OFF_W];
                        d.wb_data  = ev_upd;
                        d.st       = ev_chg ? ST_WB_DIR : ST_RD_TBL;
                    end
                end
            end
            ST_WB_DIR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) d.st = ST_RD_TBL;
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    if (ev_np || ev_prot) begin
                        d.fault      = 1'b1;
                        d.code       = {q.user, q.write, ev_prot};
                        d.fault_addr = q.vaddr;
                        d.st         = ST_IDLE;
                    end else begin
                        d.paddr   = {mem_rdata[ADDR_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                        d.pwt     = mem_rdata[BIT_PWT];
                        d.pcd     = mem_rdata[BIT_PCD];
                        d.wb_data = ev_upd;
                        if (ev_chg) begin
                            d.st = ST_WB_TBL;
                        end else begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                end
            end
            ST_WB_TBL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign fault      = q.fault;
    assign paddr      = q.paddr;
    assign pwt        = q.pwt;
    assign pcd        = q.pcd;
    assign fault_code = q.code;
    assign fault_addr = q.fault_addr;

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || fault) && !(req_valid && req_ready)) |=>
            ($stable(done) && $stable(fault) && $stable(paddr) && $stable(fault_code)));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=>
            (done && !fault && !mem_req && paddr == $past(req_vaddr)));

    // R6
    wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[BIT_P] && mem_wdata[BIT_A]));

    // R7
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !done);
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xlat_en;
    logic [19:0] dir_base;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault, pwt, pcd;
    logic [31:0] paddr, fault_addr;
    logic [2:0]  fault_code;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int wcnt = 0;

    logic [31:0] mem [logic [31:0]];
    logic [64:0] expq [$];

    // expected outcome of the current walk
    logic        e_done, e_fault, e_pwt, e_pcd, e_has_t;
    logic [2:0]  e_code;
    logic [31:0] e_paddr, e_pa, e_ta, e_pde_after, e_pte_after;

    localparam logic [31:0] P = 32'h01, RW = 32'h02, US = 32'h04, PWT = 32'h08,
                            PCD = 32'h10, ACC = 32'h20, DRT = 32'h40;

    always #5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr), .pwt(pwt), .pcd(pcd),
        .fault_code(fault_code), .fault_addr(fault_addr)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory: registered ack after lat idle cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd(mem_addr);
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // transaction monitor against the reference sequence
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 R3 unexpected memory access", mem_addr, 32'h0);
            end else begin
                logic [64:0] t;
                t = expq.pop_front();
                check(mem_we == t[64] && mem_addr == t[63:32] &&
                      (!mem_we || mem_wdata == t[31:0]),
                      "R1 R6 memory transaction", mem_addr, t[63:32]);
                if (mem_we) check(mem_wdata == t[31:0], "R6 write data",
                                  mem_wdata, t[31:0]);
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
        end
    end

    task automatic model(input logic [31:0] va, input bit w, input bit u);
        logic [31:0] pde, pte, np;
        e_done = 0; e_fault = 0; e_code = '0; e_paddr = '0;
        e_pwt = 0; e_pcd = 0; e_has_t = 0;
        e_pa = {dir_base, va[31:22], 2'b00};
        pde = rd(e_pa);
        e_pde_after = pde;
        expq.push_back({1'b0, e_pa, 32'h0});
        if (!pde[0]) begin
            e_fault = 1; e_code = {u, w, 1'b0}; return;
        end
        if ((u && !pde[2]) || (w && !pde[1])) begin
            e_fault = 1; e_code = {u, w, 1'b1}; return;
        end
        np = pde | ACC;
        if (np != pde) expq.push_back({1'b1, e_pa, np});
        e_pde_after = np;
        e_has_t = 1;
        e_ta = {pde[31:12], va[21:12], 2'b00};
        pte = rd(e_ta);
        e_pte_after = pte;
        expq.push_back({1'b0, e_ta, 32'h0});
        if (!pte[0]) begin
            e_fault = 1; e_code = {u, w, 1'b0}; return;
        end
        if ((u && !pte[2]) || (w && !pte[1])) begin
            e_fault = 1; e_code = {u, w, 1'b1}; return;
        end
        np = pte | ACC | (w ? DRT : 32'h0);
        if (np != pte) expq.push_back({1'b1, e_ta, np});
        e_pte_after = np;
        e_done = 1;
        e_paddr = {pte[31:12], va[11:0]};
        e_pwt = pte[3];
        e_pcd = pte[4];
    endtask

    task automatic walk(input logic [31:0] va, input bit w, input bit u,
                        input bit en, input int l, input string tag);
        lat = l;
        @(negedge clk);
        xlat_en = en;
        if (en) begin
            model(va, w, u);
        end else begin
            e_done = 1; e_fault = 0; e_paddr = va; e_pwt = 0; e_pcd = 0;
            e_code = fault_code; e_has_t = 0;
        end
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!(done || fault)) @(negedge clk);
        check(done == e_done, {tag, " done"}, {31'h0, done}, {31'h0, e_done});
        check(fault == e_fault, {tag, " fault"}, {31'h0, fault}, {31'h0, e_fault});
        if (e_done) begin
            check(paddr == e_paddr, {tag, " paddr"}, paddr, e_paddr);
            check(pwt == e_pwt && pcd == e_pcd, {tag, " R8 policy bits"},
                  {30'h0, pcd, pwt}, {30'h0, e_pcd, e_pwt});
        end
        if (e_fault) begin
            check(fault_code == e_code, {tag, " R7 code"},
                  {29'h0, fault_code}, {29'h0, e_code});
            check(fault_addr == va, {tag, " R7 fault_addr"}, fault_addr, va);
        end
        check(expq.size() == 0, {tag, " missing transactions"}, expq.size(), 0);
        expq.delete();
        if (en) begin
            check(rd(e_pa) == e_pde_after, {tag, " R6 dir entry"}, rd(e_pa), e_pde_after);
            if (e_has_t)
                check(rd(e_ta) == e_pte_after, {tag, " R6 table entry"},
                      rd(e_ta), e_pte_after);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; xlat_en = 1'b0; dir_base = 20'h00010;
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
        // directory at 0x10000
        mem[32'h0001_0004] = 32'h0002_0000 | P | RW | US | ACC;   // idx 1
        mem[32'h0001_0008] = 32'hFFFF_F0FE;                        // idx 2, absent
        mem[32'h0001_000C] = 32'h0002_2000 | P | RW;              // idx 3, supervisor
        mem[32'h0001_0010] = 32'h0002_3000 | P | US | ACC;        // idx 4, read-only
        mem[32'h0001_0FFC] = 32'h0002_1000 | P | RW;              // idx 1023
        // tables
        mem[32'h0002_0004] = 32'h1234_5000 | P | RW | US | ACC;
        mem[32'h0002_0008] = 32'h0000_0000;
        mem[32'h0002_1FFC] = 32'hABCD_E000 | P | RW | PWT | PCD;
        mem[32'h0002_2000] = 32'h5555_5000 | P;
        mem[32'h0002_2004] = 32'h6666_6000 | P | US;
        mem[32'h0002_3000] = 32'h7777_7000 | P | RW | US;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(req_ready && !done && !fault && !mem_req, "R10 reset state",
              {28'h0, req_ready, done, fault, mem_req}, 32'h8);

        walk(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 0, "R2 bypass");
        walk(32'h0040_1123, 1'b0, 1'b1, 1'b1, 1, "R1 R6 user read no writeback");
        walk(32'h0040_1123, 1'b1, 1'b1, 1'b1, 0, "R6 user write sets dirty");
        walk(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 2, "R1 R8 top index two writebacks");
        // R9: result stays put while no request
        begin
            logic [31:0] held;
            held = paddr;
            repeat (6) @(negedge clk);
            check(done && !fault && paddr == held && req_ready,
                  "R9 result held", paddr, held);
        end
        walk(32'h0080_0000, 1'b1, 1'b1, 1'b1, 3, "R3 dir absent garbage bits");
        walk(32'h0040_2000, 1'b0, 1'b0, 1'b1, 0, "R3 table absent");
        walk(32'h00C0_0000, 1'b0, 1'b1, 1'b1, 1, "R4 user on supervisor dir");
        walk(32'h00C0_0ABC, 1'b0, 1'b0, 1'b1, 0, "R4 supervisor on supervisor dir");
        walk(32'h00C0_1010, 1'b1, 1'b0, 1'b1, 2, "R5 supervisor write read-only table");
        walk(32'h0100_0000, 1'b1, 1'b1, 1'b1, 0, "R5 user write read-only dir");
        walk(32'h0100_0444, 1'b0, 1'b1, 1'b1, 1, "R5 user read read-only dir");
        walk(32'h1357_9BDF, 1'b1, 1'b1, 1'b0, 0, "R2 bypass after fault");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule